// File: doc/BRIEF.md
# Emulation Bus Visibility Multiplexer

This block makes on-chip bus activity observable to an external emulator through one shared set of pins. It generates a bus clock at half the core clock rate. Each bus clock period is one bus cycle. In the high phase of a bus cycle the pins carry the address of the current cycle. In the low phase they carry three fields packed together: a 3-bit access-source code, a 4-bit instruction-queue status, and the read data as the bus saw it.

An access starts with a start pulse and lasts one bus cycle. When the hold input is asserted, the access stretches over further cycles, with no limit on how many. The three low-phase fields follow a skewed pipeline. The source code appears only in the first cycle of an access. Queue status and read data follow one cycle later. The queue status is forced to null while a stretched access continues. The read data bytes are steered onto the two lanes according to access size and address alignment. A new access may start in the cycle right after the previous one ends, while the delayed fields of the previous access are still draining.

Top module: `emu_visibility_mux`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge, `vis_pins_o` is all zeros and `bus_clk_o` is low.
- R2: `bus_clk_o` toggles on every clock edge after reset. One bus cycle is one high phase followed by one low phase. The inputs are sampled at the edge that starts the high phase.
- R3: During the high phase, `vis_pins_o` equals the `acc_addr_i` sampled at the start of that bus cycle.
- R4: During the low phase, `vis_pins_o` is {source[2:0], queue[3:0], data[2*BYTE_W-1:0]}, from MSB to LSB. The source field carries `acc_src_i` only in the cycle that starts an access, and 000 in all other cycles. Source codes are 001 CPU, 010 debug external, 011 coprocessor, 100 repeat of previous cycle, 101 CPU access error, and 110/111 reserved.
- R5: A start pulse in a cycle that continues a stretched access has no effect. The source field stays 000 and the access keeps running.
- R6: The queue field and the data field shown in bus cycle n+1 come from the inputs sampled in cycle n.
- R7: The queue field is 0000 in the cycle that follows any continuation cycle. For an access of length L starting in cycle s, this covers cycles s+2 through s+L.
- R8: For a CPU word read at an even address, the upper data lane holds the byte at the address, `rd_data_i[15:8]`, and the lower lane holds the byte at address+1, `rd_data_i[7:0]`.
- R9: For a CPU word read at an odd address, the upper lane holds the byte at address+1 and the lower lane holds the byte at the address.
- R10: For a CPU byte read (`acc_word_i`=0), the byte `rd_data_i[15:8]` goes on the upper lane if address bit 0 is 0, and the lower lane carries `acc_addr_i[7:0]`. If address bit 0 is 1, the byte goes on the lower lane and the upper lane carries `acc_addr_i[15:8]`.
- R11: The data field is zero unless the sampled cycle started an access with source 001 and `acc_rd_i`=1.
- R12: An access that starts in the cycle right after another access ends shows its own source code in its first cycle. The previous access's queue status and data still appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_go_i | input | 1 | Starts an access in this bus cycle |
| acc_hold_i | input | 1 | Current access continues into the next bus cycle |
| acc_src_i | input | 3 | Access-source code |
| acc_rd_i | input | 1 | 1 for read, 0 for write |
| acc_word_i | input | 1 | 1 for word access, 0 for byte access |
| acc_addr_i | input | 2*BYTE_W+7 | Access address |
| rd_data_i | input | 2*BYTE_W | Read data; upper byte is at the address, lower byte at address+1 |
| qst_i | input | 4 | Instruction-queue status for this bus cycle |
| bus_clk_o | output | 1 | External bus clock; high phase shows the address |
| vis_pins_o | output | 2*BYTE_W+7 | Multiplexed visibility pins |

## Verification
The bench builds the block with BYTE_W=8, which gives 16-bit data lanes and a 23-bit pin set. At this width, every steering case can be told apart, including the address repeats on the lanes. Random stimulus with a 30 percent hold probability produces stretched accesses of several cycles, starts that arrive during continuations, and back-to-back accesses. Directed sequences pin down each lane arrangement and the exact cycles in which the queue field is null.

// File: rtl/emu_vis_pkg.sv
package emu_vis_pkg;
  localparam int SRC_W = 3;
  localparam int QST_W = 4;

  localparam logic [SRC_W-1:0] SRC_NONE    = 3'b000;
  localparam logic [SRC_W-1:0] SRC_CPU     = 3'b001;
  localparam logic [SRC_W-1:0] SRC_DBG_EXT = 3'b010;
  localparam logic [SRC_W-1:0] SRC_COPRO   = 3'b011;
  localparam logic [SRC_W-1:0] SRC_REPEAT  = 3'b100;
  localparam logic [SRC_W-1:0] SRC_CPU_ERR = 3'b101;

  localparam logic [QST_W-1:0] QST_NULL = '0;
endpackage

// File: rtl/vis_phase_gen.sv
module vis_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic phase_o,
  output logic capture_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) phase_o <= 1'b0;
    else        phase_o <= !phase_o;
  end

  // The edge leaving the low phase opens a new bus cycle.
  assign capture_o = !phase_o;

  assert_phase_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_o |=> phase_o);
  assert_phase_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o |=> !phase_o);
endmodule

// File: rtl/vis_access_track.sv
module vis_access_track
  import emu_vis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic             go_i,
  input  logic             hold_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [QST_W-1:0] qst_i,
  output logic             start_o,
  output logic             cont_o,
  output logic [SRC_W-1:0] acc_field_o,
  output logic [QST_W-1:0] qst_field_o
);
  logic             pending_q;
  logic             in_access;
  logic [SRC_W-1:0] acc_q;
  logic [QST_W-1:0] qst_stage_q;
  logic [QST_W-1:0] qst_show_q;

  assign cont_o    = pending_q;
  assign start_o   = go_i && !pending_q;
  assign in_access = start_o || pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q   <= 1'b0;
      acc_q       <= SRC_NONE;
      qst_stage_q <= QST_NULL;
      qst_show_q  <= QST_NULL;
    end else if (capture_i) begin
      pending_q   <= in_access && hold_i;
      acc_q       <= start_o ? src_i : SRC_NONE;
      qst_stage_q <= pending_q ? QST_NULL : qst_i;
      qst_show_q  <= qst_stage_q;
    end
  end

  assign acc_field_o = acc_q;
  assign qst_field_o = qst_show_q;

  // R4 / R5: a continuation cycle never shows a source code.
  assert_acc_null_in_cont_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && cont_o) |=> (acc_field_o == SRC_NONE));
  // R12: a start right after an access ends shows its own code.
  assert_b2b_src_shown_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !cont_o && go_i) |=> (acc_field_o == $past(src_i)));
  // R7: the staged queue status is nulled after a continuation cycle.
  assert_qst_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && cont_o) |=> (qst_stage_q == QST_NULL));
endmodule

// File: rtl/vis_lane_steer.sv
module vis_lane_steer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              valid_i,
  input  logic              word_i,
  input  logic [LANE_W-1:0] addr_lo_i,
  input  logic [LANE_W-1:0] rdata_i,
  output logic [LANE_W-1:0] ivd_o
);
  localparam int LANE_W = 2 * BYTE_W;

  function automatic logic [LANE_W-1:0] steer_lanes(
    input logic              word,
    input logic [LANE_W-1:0] addr,
    input logic [LANE_W-1:0] data
  );
    logic [BYTE_W-1:0] at_addr;
    logic [BYTE_W-1:0] at_next;
    at_addr = data[LANE_W-1:BYTE_W];
    at_next = data[BYTE_W-1:0];
    case ({word, addr[0]})
      2'b10:   return {at_addr, at_next};
      2'b11:   return {at_next, at_addr};
      2'b00:   return {at_addr, addr[BYTE_W-1:0]};
      default: return {addr[LANE_W-1:BYTE_W], at_addr};
    endcase
  endfunction

  logic [LANE_W-1:0] steered;
  logic [LANE_W-1:0] ivd_stage_q;
  logic [LANE_W-1:0] ivd_show_q;

  assign steered = valid_i ? steer_lanes(word_i, addr_lo_i, rdata_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivd_stage_q <= '0;
      ivd_show_q  <= '0;
    end else if (capture_i) begin
      ivd_stage_q <= steered;
      ivd_show_q  <= ivd_stage_q;
    end
  end

  assign ivd_o = ivd_show_q;

  assert_ivd_invalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !valid_i) |=> (ivd_stage_q == '0));
  assert_word_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && valid_i && word_i && !addr_lo_i[0]) |=> (ivd_stage_q == $past(rdata_i)));
  // R6: the shown value is the one staged a bus cycle earlier.
  assert_ivd_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> (ivd_show_q == $past(ivd_stage_q)));
endmodule

// File: rtl/emu_visibility_mux.sv
module emu_visibility_mux
  import emu_vis_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_go_i,
  input  logic                       acc_hold_i,
  input  logic [2:0]                 acc_src_i,
  input  logic                       acc_rd_i,
  input  logic                       acc_word_i,
  input  logic [2*BYTE_W+6:0]        acc_addr_i,
  input  logic [2*BYTE_W-1:0]        rd_data_i,
  input  logic [3:0]                 qst_i,
  output logic                       bus_clk_o,
  output logic [2*BYTE_W+6:0]        vis_pins_o
);
  localparam int LANE_W = 2 * BYTE_W;
  localparam int PIN_W  = SRC_W + QST_W + LANE_W;

  logic             capture;
  logic             start;
  logic             cont;
  logic             cpu_read_start;
  logic [SRC_W-1:0] acc_field;
  logic [QST_W-1:0] qst_field;
  logic [LANE_W-1:0] ivd_field;

  vis_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_o   (bus_clk_o),
    .capture_o (capture)
  );

  vis_access_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_i   (capture),
    .go_i        (acc_go_i),
    .hold_i      (acc_hold_i),
    .src_i       (acc_src_i),
    .qst_i       (qst_i),
    .start_o     (start),
    .cont_o      (cont),
    .acc_field_o (acc_field),
    .qst_field_o (qst_field)
  );

  assign cpu_read_start = start && (acc_src_i == SRC_CPU) && acc_rd_i;

  vis_lane_steer #(.BYTE_W(BYTE_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .valid_i   (cpu_read_start),
    .word_i    (acc_word_i),
    .addr_lo_i (acc_addr_i[LANE_W-1:0]),
    .rdata_i   (rd_data_i),
    .ivd_o     (ivd_field)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       vis_pins_o <= '0;
    else if (capture) vis_pins_o <= acc_addr_i;
    else              vis_pins_o <= {acc_field, qst_field, ivd_field};
  end

  assert_addr_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (vis_pins_o == $past(acc_addr_i)));
  assert_low_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && cont) |=> ##1 (vis_pins_o[PIN_W-1 -: SRC_W] == SRC_NONE));
endmodule

// File: tb/emu_visibility_mux_tb.sv
module emu_visibility_mux_tb;
  localparam int BYTE_W = 8;
  localparam int LANE_W = 2 * BYTE_W;
  localparam int PIN_W  = LANE_W + 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              go, hold, rd, word;
  logic [2:0]        src;
  logic [PIN_W-1:0]  addr;
  logic [LANE_W-1:0] data;
  logic [3:0]        qst;
  logic              bus_clk;
  logic [PIN_W-1:0]  pins;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic              m_pend = 1'b0;
  logic              m_prev_end = 1'b0;
  logic [3:0]        m_q_stage = '0, m_q_show = '0;
  logic [LANE_W-1:0] m_d_stage = '0, m_d_show = '0;
  string             m_d_tag_stage = "R11", m_d_tag_show = "R11";
  string             m_q_tag_stage = "R6",  m_q_tag_show = "R6";

  always #10 clk = !clk;

  emu_visibility_mux #(.BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_go_i(go), .acc_hold_i(hold),
    .acc_src_i(src), .acc_rd_i(rd), .acc_word_i(word), .acc_addr_i(addr),
    .rd_data_i(data), .qst_i(qst), .bus_clk_o(bus_clk), .vis_pins_o(pins)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Lane arrangement restated by byte selection.
  function automatic logic [LANE_W-1:0] exp_lanes(input logic w, input logic [PIN_W-1:0] a,
                                                  input logic [LANE_W-1:0] d);
    logic [7:0] b0, b1;
    b0 = d[15:8];
    b1 = d[7:0];
    if (w)          return a[0] ? {b1, b0} : {b0, b1};
    else if (!a[0]) return {b0, a[7:0]};
    else            return {a[15:8], b0};
  endfunction

  function automatic string lane_tag(input logic w, input logic a0);
    if (w) return a0 ? "R9" : "R8";
    return "R10";
  endfunction

  // Called at a negedge during the low phase; runs one full bus cycle.
  task automatic bus_cycle(input logic g, input logic h, input logic [2:0] s, input logic r,
                           input logic w, input logic [PIN_W-1:0] a,
                           input logic [LANE_W-1:0] d, input logic [3:0] q);
    logic       cont, start;
    logic [2:0] e_src;
    string      src_tag;
    go = g; hold = h; src = s; rd = r; word = w; addr = a; data = d; qst = q;
    cont  = m_pend;
    start = g && !cont;
    e_src = start ? s : 3'b000;
    src_tag = (g && cont) ? "R5" : ((start && m_prev_end) ? "R12" : "R4");
    // shift the delayed fields
    m_q_show = m_q_stage; m_q_tag_show = m_q_tag_stage;
    m_d_show = m_d_stage; m_d_tag_show = m_d_tag_stage;
    m_q_stage = cont ? 4'h0 : q;
    m_q_tag_stage = cont ? "R7" : "R6";
    if (start && s == 3'b001 && r) begin
      m_d_stage = exp_lanes(w, a, d);
      m_d_tag_stage = lane_tag(w, a[0]);
    end else begin
      m_d_stage = '0;
      m_d_tag_stage = "R11";
    end
    m_prev_end = (start || cont) && !h;
    m_pend = (start || cont) && h;
    @(posedge clk); @(negedge clk);
    chk("R2", {31'd0, bus_clk}, 32'd1);
    chk("R3", {9'd0, pins}, {9'd0, a});
    @(posedge clk); @(negedge clk);
    chk("R2", {31'd0, bus_clk}, 32'd0);
    chk(src_tag, {29'd0, pins[PIN_W-1 -: 3]}, {29'd0, e_src});
    chk(m_q_tag_show, {28'd0, pins[LANE_W +: 4]}, {28'd0, m_q_show});
    chk(m_d_tag_show, {16'd0, pins[LANE_W-1:0]}, {16'd0, m_d_show});
  endtask

  task automatic idle();
    bus_cycle(0, 0, 3'b000, 0, 0, '0, '0, 4'h0);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    go = 0; hold = 0; src = 0; rd = 0; word = 0; addr = '0; data = '0; qst = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {9'd0, pins}, 32'd0);
    chk("R1", {31'd0, bus_clk}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    // first edge after reset: now in high phase, pins still NULL until... address loaded
    chk("R3", {9'd0, pins}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R1", {31'd0, bus_clk}, 32'd0);
    m_pend = 0; m_prev_end = 0;

    // directed: lane steering for each size/alignment
    bus_cycle(1, 0, 3'b001, 1, 1, 23'h012340, 16'hA1B2, 4'h3);
    bus_cycle(1, 0, 3'b001, 1, 1, 23'h012341, 16'hC3D4, 4'h5);
    bus_cycle(1, 0, 3'b001, 1, 0, 23'h05AB6C, 16'hE5F6, 4'h7);
    bus_cycle(1, 0, 3'b001, 1, 0, 23'h05AB6D, 16'h1788, 4'h9);
    // non CPU read / CPU write
    bus_cycle(1, 0, 3'b010, 1, 1, 23'h000100, 16'h9999, 4'hA);
    bus_cycle(1, 0, 3'b001, 0, 1, 23'h000102, 16'h8888, 4'hB);
    idle();
    // stretched access of four cycles, start pulses during continuation
    bus_cycle(1, 1, 3'b001, 1, 1, 23'h002000, 16'h4455, 4'hC);
    bus_cycle(1, 1, 3'b011, 1, 1, 23'h002000, 16'h0000, 4'hD);
    bus_cycle(0, 1, 3'b000, 1, 1, 23'h002000, 16'h0000, 4'hE);
    bus_cycle(1, 0, 3'b101, 1, 1, 23'h002000, 16'h0000, 4'hF);
    // back-to-back start right after the end
    bus_cycle(1, 1, 3'b100, 1, 0, 23'h003001, 16'h6677, 4'h1);
    bus_cycle(0, 0, 3'b000, 1, 0, 23'h003001, 16'h0000, 4'h2);
    bus_cycle(1, 0, 3'b001, 1, 1, 23'h003004, 16'hBEEF, 4'h4);
    idle();
    idle();

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic g, h, r, w;
      logic [2:0] s;
      g = ($urandom() % 2) == 0;
      h = ($urandom() % 10) < 3;
      r = ($urandom() % 4) != 0;
      w = $urandom() % 2;
      s = ($urandom() % 2) ? 3'b001 : 3'($urandom() % 8);
      bus_cycle(g, h, s, r, w, 23'($urandom()), 16'($urandom()), 4'($urandom()));
    end
    idle();
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule